// File: doc/BRIEF.md
# PSRAM Low-Power State Sequencer

This block follows the power state of a pseudo-static RAM die and tells the rest of the memory controller whether host access and self-refresh are currently allowed. It watches an active-low select input and two single-cycle event inputs: one pulses whenever any address or control input changes, and one pulses when a read or write finishes. From these it moves between an active state, a selected-but-idle reduced-power state and a deselected standby state, in which only refresh keeps running.

A deep power-down request is held as a single armed bit, loaded by a configuration write. The bit does not act at once. The die drops into deep power-down only at the next deselect taken from an active or reduced-power state. Refresh then stops and a sticky data-lost flag is raised. To leave deep power-down, select must stay low without a break for a set number of timebase ticks. An initialization wait of a further set number of ticks follows, and host access stays blocked for all of it. All intervals are counted in ticks of an external timebase, so the tick period sets the scale (1 µs gives 10 and 150 ticks for the default hold and init windows).

Top module: `psram_power_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pwr_state is STANDBY, ready and refresh_ok are 1, and data_lost is 0. The state encoding is ACTIVE=0, STANDBY=1, LOWPWR=2, DPD=3, INIT=4. Each state change shows on pwr_state one clock after the edge that samples its cause.
- R2: In STANDBY, sel_n low moves the state to ACTIVE. sel_n high in ACTIVE or LOWPWR moves it to STANDBY when the power-down bit is not armed.
- R3: An op_done pulse in ACTIVE moves the state to LOWPWR. An act_pulse in LOWPWR returns it to ACTIVE.
- R4: In ACTIVE, IDLE_TICKS ticks in a row without an act_pulse move the state to LOWPWR. An act_pulse restarts the count.
- R5: cfg_wr with cfg_dpd=1 arms deep power-down. The armed bit takes effect only at the next sel_n high seen in ACTIVE or LOWPWR, which then enters DPD. A device already in STANDBY stays there while sel_n stays high.
- R6: In DPD, ready and refresh_ok are 0. data_lost is set on every entry into DPD and stays set until an op_done is seen while ready is 1.
- R7: The state leaves DPD for INIT only after HOLD_TICKS ticks with sel_n continuously low. sel_n high at any edge in DPD restarts the hold count.
- R8: INIT lasts INIT_TICKS ticks, with ready 0 and refresh_ok 1. It then goes to ACTIVE if sel_n is low and to STANDBY if sel_n is high.
- R9: Leaving DPD clears the armed bit. cfg_wr is ignored in DPD and INIT, so a later deselect leads to STANDBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low chip select from the host |
| act_pulse | input | 1 | One-cycle pulse on any address or control input change |
| op_done | input | 1 | One-cycle pulse when a read or write completes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dpd | input | 1 | Deep power-down bit value carried by cfg_wr |
| tick | input | 1 | Timebase tick, one cycle wide |
| pwr_state | output | 3 | Current power state (encoding in R1) |
| ready | output | 1 | Host access permitted |
| refresh_ok | output | 1 | Self-refresh permitted |
| data_lost | output | 1 | Sticky flag: contents lost through deep power-down |

## Verification
The embedded properties assume that tick, act_pulse, op_done and cfg_wr are single-cycle pulses sampled on the clock. They also assume sel_n changes only between edges, so each transition can be tied to the input values one edge earlier. The directed bench drives every input just after the falling edge and holds tick high for whole stretches while timing windows are exercised. That makes each tick one clock, so the hold, init and idle boundaries fall on exact cycle counts, checked one cycle before and at the expected edge. The bench overrides the tick counts with small values so every window is reached quickly.

// File: rtl/psram_pwr_pkg.sv
// Shared power-state type for the PSRAM low-power sequencer.
// Assumes: the encoding is visible on the top-level state port.
package psram_pwr_pkg;
    typedef enum logic [2:0] {
        PS_ACTIVE  = 3'd0,
        PS_STANDBY = 3'd1,
        PS_LOWPWR  = 3'd2,
        PS_DPD     = 3'd3,
        PS_INIT    = 3'd4
    } pwr_state_t;
endpackage

// File: rtl/psram_tick_timer.sv
// Counts timebase ticks while run is high and flags the tick that completes
// LIMIT ticks. clr restarts the count and takes priority over counting.
// Assumes: LIMIT >= 1, tick is one clock wide.
module psram_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt;

    // Completion: the tick that would make the count reach LIMIT.
    assign done = !clr && run && tick && (cnt == CW'(LIMIT - 1));

    // Tick counter: restarts on clr or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || done) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/psram_dpd_flags.sv
// Holds the armed deep power-down bit and the sticky data-lost flag.
// Assumes: enter_dpd and exit_dpd are never high together.
module psram_dpd_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_dpd,
    input  logic cfg_allow,
    input  logic enter_dpd,
    input  logic exit_dpd,
    input  logic clear_lost,
    output logic dpd_armed,
    output logic data_lost
);
    // Armed bit: cleared by a power-down exit, else loaded by an allowed write.
    always_ff @(posedge clk) begin
        if (!rst_n || exit_dpd) begin
            dpd_armed <= 1'b0;
        end else if (cfg_wr && cfg_allow) begin
            dpd_armed <= cfg_dpd;
        end
    end

    // Data-lost flag: set on every entry, cleared when fresh data is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_lost <= 1'b0;
        end else if (enter_dpd) begin
            data_lost <= 1'b1;
        end else if (clear_lost) begin
            data_lost <= 1'b0;
        end
    end

    assert_exit_clears_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exit_dpd |=> !dpd_armed);
endmodule

// File: rtl/psram_power_seq.sv
// Top of the PSRAM low-power sequencer: state register, next-state logic,
// hold / init / idle timers and the power-down flag holder.
// Assumes: act_pulse, op_done, cfg_wr and tick are single-cycle pulses
// synchronous to clk, and sel_n is already synchronized.
module psram_power_seq
    import psram_pwr_pkg::*;
#(
    parameter int HOLD_TICKS = 10,
    parameter int INIT_TICKS = 150,
    parameter int IDLE_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       act_pulse,
    input  logic       op_done,
    input  logic       cfg_wr,
    input  logic       cfg_dpd,
    input  logic       tick,
    output logic [2:0] pwr_state,
    output logic       ready,
    output logic       refresh_ok,
    output logic       data_lost
);
    pwr_state_t state_q, state_d;
    logic hold_done, init_done, idle_done;
    logic dpd_armed;
    logic enter_dpd, exit_dpd;

    psram_tick_timer #(.LIMIT(HOLD_TICKS)) i_hold_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != PS_DPD || sel_n),
        .run  (state_q == PS_DPD),
        .tick (tick),
        .done (hold_done)
    );

    psram_tick_timer #(.LIMIT(INIT_TICKS)) i_init_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != PS_INIT),
        .run  (state_q == PS_INIT),
        .tick (tick),
        .done (init_done)
    );

    psram_tick_timer #(.LIMIT(IDLE_TICKS)) i_idle_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != PS_ACTIVE || act_pulse),
        .run  (state_q == PS_ACTIVE),
        .tick (tick),
        .done (idle_done)
    );

    // Next state: deselect first, then completion and idle events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_STANDBY: if (!sel_n) state_d = PS_ACTIVE;
            PS_ACTIVE: begin
                if (sel_n)          state_d = dpd_armed ? PS_DPD : PS_STANDBY;
                else if (op_done)   state_d = PS_LOWPWR;
                else if (idle_done) state_d = PS_LOWPWR;
            end
            PS_LOWPWR: begin
                if (sel_n)          state_d = dpd_armed ? PS_DPD : PS_STANDBY;
                else if (act_pulse) state_d = PS_ACTIVE;
            end
            PS_DPD:  if (hold_done) state_d = PS_INIT;
            PS_INIT: if (init_done) state_d = sel_n ? PS_STANDBY : PS_ACTIVE;
            default: state_d = PS_STANDBY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_STANDBY;
        else        state_q <= state_d;
    end

    assign enter_dpd = (state_q != PS_DPD) && (state_d == PS_DPD);
    assign exit_dpd  = (state_q == PS_DPD) && (state_d == PS_INIT);

    psram_dpd_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dpd   (cfg_dpd),
        .cfg_allow (state_q != PS_DPD && state_q != PS_INIT),
        .enter_dpd (enter_dpd),
        .exit_dpd  (exit_dpd),
        .clear_lost(op_done && ready),
        .dpd_armed (dpd_armed),
        .data_lost (data_lost)
    );

    assign pwr_state  = state_q;
    assign ready      = (state_q != PS_DPD) && (state_q != PS_INIT);
    assign refresh_ok = (state_q != PS_DPD);

    assert_dpd_entry_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DPD && $past(state_q) != PS_DPD) |-> ($past(dpd_armed) && $past(sel_n)));
    assert_dpd_sets_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DPD && $past(state_q) != PS_DPD) |-> data_lost);
    assert_dpd_exit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_DPD && $past(state_q) == PS_DPD) |-> (!$past(sel_n) && $past(tick)));
    assert_init_after_dpd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_INIT && $past(state_q) != PS_INIT) |-> $past(state_q) == PS_DPD);
    assert_init_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_INIT) |-> !dpd_armed);
endmodule

// File: tb/test_psram_power_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module test_psram_power_seq;
    localparam int HOLD = 4;
    localparam int INIT = 6;
    localparam int IDLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, act_pulse = 1'b0, op_done = 1'b0;
    logic cfg_wr = 1'b0, cfg_dpd = 1'b0, tick = 1'b0;
    logic [2:0] pwr_state;
    logic ready, refresh_ok, data_lost;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    psram_power_seq #(.HOLD_TICKS(HOLD), .INIT_TICKS(INIT), .IDLE_TICKS(IDLE)) i_psram_power_seq (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .act_pulse(act_pulse),
        .op_done(op_done), .cfg_wr(cfg_wr), .cfg_dpd(cfg_dpd), .tick(tick),
        .pwr_state(pwr_state), .ready(ready), .refresh_ok(refresh_ok),
        .data_lost(data_lost)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int got, input int exp, input string req);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic pulse_act();
        act_pulse = 1'b1; step(1); act_pulse = 1'b0;
    endtask

    task automatic pulse_done();
        op_done = 1'b1; step(1); op_done = 1'b0;
    endtask

    task automatic arm(input logic v);
        cfg_wr = 1'b1; cfg_dpd = v; step(1); cfg_wr = 1'b0; cfg_dpd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        check(pwr_state, 1, "R1 reset state");
        check(ready, 1, "R1 reset ready");
        check(refresh_ok, 1, "R1 reset refresh");
        check(data_lost, 0, "R1 reset data_lost");
    endtask

    task automatic t_select();
        sel_n = 1'b0; step(1);
        check(pwr_state, 0, "R2 select to ACTIVE");
        sel_n = 1'b1; step(1);
        check(pwr_state, 1, "R2 deselect to STANDBY");
    endtask

    task automatic t_lowpwr();
        sel_n = 1'b0; step(1);
        pulse_done();
        check(pwr_state, 2, "R3 op_done to LOWPWR");
        pulse_act();
        check(pwr_state, 0, "R3 activity to ACTIVE");
        pulse_done();
        sel_n = 1'b1; step(1);
        check(pwr_state, 1, "R2 LOWPWR deselect to STANDBY");
    endtask

    task automatic t_idle();
        sel_n = 1'b0; step(1);
        tick = 1'b1;
        step(IDLE - 1);
        check(pwr_state, 0, "R4 idle one tick early");
        step(1);
        check(pwr_state, 2, "R4 idle timeout");
        pulse_act();
        step(2);
        pulse_act();
        step(IDLE - 1);
        check(pwr_state, 0, "R4 activity restarts idle");
        step(1);
        check(pwr_state, 2, "R4 idle after restart");
        tick = 1'b0;
        pulse_act();
        sel_n = 1'b1; step(1);
    endtask

    task automatic t_arm_and_enter();
        arm(1'b1);
        step(3);
        check(pwr_state, 1, "R5 armed in STANDBY stays STANDBY");
        sel_n = 1'b0; step(1);
        check(pwr_state, 0, "R5 select while armed");
        sel_n = 1'b1; step(1);
        check(pwr_state, 3, "R5 deselect enters DPD");
        check(ready, 0, "R6 DPD ready");
        check(refresh_ok, 0, "R6 DPD refresh");
        check(data_lost, 1, "R6 data_lost on entry");
    endtask

    task automatic t_hold_and_init();
        tick = 1'b1;
        sel_n = 1'b0; step(2);
        sel_n = 1'b1; step(1);
        check(pwr_state, 3, "R7 short hold stays DPD");
        sel_n = 1'b0; step(HOLD - 1);
        check(pwr_state, 3, "R7 one tick before exit");
        step(1);
        check(pwr_state, 4, "R7 hold complete to INIT");
        check(ready, 0, "R8 INIT ready");
        check(refresh_ok, 1, "R8 INIT refresh");
        arm(1'b1);
        step(INIT - 2);
        check(pwr_state, 4, "R8 INIT one tick early");
        step(1);
        check(pwr_state, 0, "R8 INIT done to ACTIVE");
        check(ready, 1, "R8 ready after INIT");
        tick = 1'b0;
        sel_n = 1'b1; step(1);
        check(pwr_state, 1, "R9 unarmed after exit and ignored write");
    endtask

    task automatic t_clear_and_repeat();
        check(data_lost, 1, "R6 data_lost sticky");
        sel_n = 1'b0; step(1);
        pulse_done();
        check(data_lost, 0, "R6 data_lost cleared by write");
        pulse_act();
        arm(1'b1);
        sel_n = 1'b1; step(1);
        check(pwr_state, 3, "R5 second DPD entry");
        check(data_lost, 1, "R6 data_lost on second entry");
        tick = 1'b1;
        sel_n = 1'b0; step(HOLD);
        check(pwr_state, 4, "R7 second exit");
        sel_n = 1'b1; step(INIT);
        check(pwr_state, 1, "R8 INIT done to STANDBY");
        tick = 1'b0;
    endtask

    initial begin
        step(1);
        t_reset();
        t_select();
        t_lowpwr();
        t_idle();
        t_arm_and_enter();
        t_hold_and_init();
        t_clear_and_repeat();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule